// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Controller

This block drives a common-cathode LED display of 8 or 16 digits by time multiplexing. A host fills a small bank of 16-bit registers through a plain write port (address, data, enable). The block scans the digits one after another and, for the digit being lit, produces an eight-line segment word and a one-hot digit select.

Two register layouts are available, chosen by a mode input. In decode mode the host supplies a 4-bit code for each digit, and a fixed font turns the code into segments. A separate register holds one decimal-point bit per digit. In raw mode the host supplies one segment byte per digit, which drives the segments as written.

Host writes go into a staging bank and reach the display only at a digit-slot boundary, so a digit never changes while it is lit. The mode input is taken up at the same boundary.

Top module: `segscan_ctrl`

## Requirements
- R1: During reset all registers clear, digit 0 is selected and the mode input is taken up. After reset, every digit shows glyph '0' (seg_out 0x7E) in decode mode and is dark (0x00) in raw mode.
- R2: digit_sel is one-hot, with bit i selecting digit i and digit 0 the rightmost. Each digit is held for SLOT_CYCLES clocks. Digits follow in ascending order, and digit 0 follows digit NUM_DIGITS-1.
- R3: seg_out is 0x00 in the first clock of every digit slot, whatever the register contents.
- R4: In decode mode, seg_out[6:0] = {a,b,c,d,e,f,g} comes from the digit's code through this font: 0:7E 1:30 2:6D 3:79 4:33 5:5B 6:5F 7:72 8:7F 9:7B A:01 (dash) B:4F C:37 D:0D E:0F F:00 (blank).
- R5: In decode mode, digit d takes its code from register 1+d/4, bits [4*(d%4)+3 : 4*(d%4)].
- R6: In decode mode, seg_out[7] (decimal point) equals bit d of register 0 while digit d is lit. A 1 lights the point.
- R7: In raw mode, digit d shows byte d%2 of register d/2 (bits 7..0 for even d, bits 15..8 for odd d). The byte is passed unchanged as seg_out = {dp,a,b,c,d,e,f,g}.
- R8: A register write, or a change of the mode input, made during a digit slot leaves that slot's output unchanged and is visible from the next slot.
- R9: A write whose address is not below the register count of the mode input at the time of the write (1+NUM_DIGITS/4 in decode mode, NUM_DIGITS/2 in raw mode) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_decode | input | 1 | 1 = decode layout, 0 = raw segment layout |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register index, ADDR_W = log2(NUM_DIGITS/2)+1 |
| wr_data | input | 16 | Register write data |
| seg_out | output | 8 | Segment lines {dp,a,b,c,d,e,f,g}, active high |
| digit_sel | output | NUM_DIGITS | One-hot digit enable, bit 0 = rightmost digit |

## Verification
The bench sweeps every font code across every digit position, together with assorted decimal-point patterns and a walking segment bit in raw mode. A wrong nibble or byte offset would show up as the wrong glyph on a neighbouring digit, and a swapped bit would light the wrong segment. It writes in the middle of a lit slot and changes the mode in the middle of a slot. A design that updates at once would alter a digit while it is lit, and one that waits too long would miss the next slot. It also writes to addresses that only the other layout uses, then switches layout. A design that accepts those writes would show corrupted digits. The first-clock blanking is checked on data that would otherwise light segments, and scan wrap-around is checked after the last digit.

// File: rtl/segscan_pkg.sv
// Package segscan_pkg
// Shared segment word type and the decode-mode font.
// Assumes segment words are ordered {dp,a,b,c,d,e,f,g}, active high.
package segscan_pkg;

    typedef logic [7:0] seg_t;

    // Maps a 4-bit digit code to segments a..g (bit 6 = a, bit 0 = g).
    function automatic logic [6:0] glyph7(input logic [3:0] code);
        logic [6:0] pat;
        case (code)
            4'h0: pat = 7'h7E;
            4'h1: pat = 7'h30;
            4'h2: pat = 7'h6D;
            4'h3: pat = 7'h79;
            4'h4: pat = 7'h33;
            4'h5: pat = 7'h5B;
            4'h6: pat = 7'h5F;
            4'h7: pat = 7'h72;
            4'h8: pat = 7'h7F;
            4'h9: pat = 7'h7B;
            4'hA: pat = 7'h01;
            4'hB: pat = 7'h4F;
            4'hC: pat = 7'h37;
            4'hD: pat = 7'h0D;
            4'hE: pat = 7'h0F;
            default: pat = 7'h00;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/segscan_timer.sv
// Module segscan_timer
// Slot prescaler and digit index. Every digit is lit for SLOT_CYCLES
// clocks, and the index steps upward and wraps after the last digit.
// Assumes SLOT_CYCLES >= 2 and NUM_DIGITS is a power of two.
module segscan_timer #(
    parameter int NUM_DIGITS  = 8,
    parameter int SLOT_CYCLES = 4,
    localparam int IDX_W = $clog2(NUM_DIGITS),
    localparam int CNT_W = $clog2(SLOT_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] digit_idx,
    output logic [CNT_W-1:0] slot_cnt,
    output logic             slot_last
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);

    assign slot_last = (slot_cnt == CNT_LAST);

    // Counts clocks within a slot and steps the digit index at the slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt  <= '0;
            digit_idx <= '0;
        end else if (slot_last) begin
            slot_cnt  <= '0;
            digit_idx <= (digit_idx == IDX_LAST) ? '0 : digit_idx + IDX_W'(1);
        end else begin
            slot_cnt  <= slot_cnt + CNT_W'(1);
        end
    end

    // R2: the index holds inside a slot
    a_r2_hold_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_last |=> $stable(digit_idx));

    // R2: the index advances by one, wrapping after the last digit
    a_r2_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> digit_idx == (($past(digit_idx) == IDX_LAST) ? '0
                                    : $past(digit_idx) + IDX_W'(1)));

endmodule

// File: rtl/segscan_regbank.sv
// Module segscan_regbank
// Host-writable staging registers plus the display copy that is loaded
// at every slot boundary, together with the mode input.
// Assumes the write range is judged against the live mode input.
module segscan_regbank #(
    parameter int NUM_DIGITS = 8,
    localparam int NREG   = NUM_DIGITS / 2,
    localparam int ADDR_W = $clog2(NREG) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [15:0]           wr_data,
    input  logic                  mode_decode,
    input  logic                  slot_last,
    output logic [NREG-1:0][15:0] view_regs,
    output logic                  view_decode
);

    localparam int DEC_REGS = 1 + NUM_DIGITS / 4;
    localparam logic [ADDR_W-1:0] DEC_LIM = ADDR_W'(DEC_REGS);
    localparam logic [ADDR_W-1:0] RAW_LIM = ADDR_W'(NREG);

    logic [15:0] stage [NREG];
    logic        addr_ok;

    assign addr_ok = wr_addr < (mode_decode ? DEC_LIM : RAW_LIM);

    for (genvar r = 0; r < NREG; r++) begin : g_stage
        // Accepts an in-range host write into staging register r.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage[r] <= '0;
            else if (wr_en && addr_ok && wr_addr == ADDR_W'(r))
                stage[r] <= wr_data;
        end

        // R9: out-of-range writes leave staging untouched
        a_r9_ignore_range: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !addr_ok) |=> $stable(stage[r]));
    end

    // Loads the display copy and the mode at each slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view_regs   <= '0;
            view_decode <= mode_decode;
        end else if (slot_last) begin
            for (int r = 0; r < NREG; r++) view_regs[r] <= stage[r];
            view_decode <= mode_decode;
        end
    end

    // R8: the displayed contents change only at a slot boundary
    a_r8_view_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_last |=> ($stable(view_regs) && $stable(view_decode)));

endmodule

// File: rtl/segscan_glyph.sv
// Module segscan_glyph
// Selects the lit digit's field from the display copy and forms its
// segment word, either through the font or as a raw byte, with blanking.
// Assumes NUM_DIGITS is 8 or 16.
module segscan_glyph
    import segscan_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    localparam int NREG  = NUM_DIGITS / 2,
    localparam int IDX_W = $clog2(NUM_DIGITS),
    localparam int REG_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][15:0] view_regs,
    input  logic                  view_decode,
    input  logic [IDX_W-1:0]      digit_idx,
    input  logic                  blank,
    output seg_t                  seg
);

    logic [REG_W-1:0] dec_sel;
    logic [REG_W-1:0] raw_sel;
    logic [3:0]       nib_lo;
    logic [3:0]       byte_lo;
    logic [3:0]       dp_pos;
    logic [3:0]       code;
    logic             dp;
    logic [7:0]       raw;

    // Computes which register and bit offset hold the lit digit.
    always_comb begin
        dec_sel = REG_W'((digit_idx >> 2) + IDX_W'(1));
        raw_sel = REG_W'(digit_idx >> 1);
        nib_lo  = {digit_idx[1:0], 2'b00};
        byte_lo = {digit_idx[0], 3'b000};
        dp_pos  = 4'(digit_idx);
    end

    // Picks the digit's code, decimal point and raw byte, then forms segments.
    always_comb begin
        code = view_regs[dec_sel][nib_lo +: 4];
        dp   = view_regs[0][dp_pos];
        raw  = view_regs[raw_sel][byte_lo +: 8];
        if (blank)
            seg = '0;
        else if (view_decode)
            seg = {dp, glyph7(code)};
        else
            seg = raw;
    end

endmodule

// File: rtl/segscan_ctrl.sv
// Module segscan_ctrl
// Top of the multiplexed seven-segment controller: timer, register bank
// and glyph former, plus the one-hot digit select.
// Assumes a common-cathode display with active-high segment and digit lines.
module segscan_ctrl
    import segscan_pkg::*;
#(
    parameter int NUM_DIGITS  = 8,
    parameter int SLOT_CYCLES = 4,
    localparam int ADDR_W = $clog2(NUM_DIGITS / 2) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_decode,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [15:0]           wr_data,
    output logic [7:0]            seg_out,
    output logic [NUM_DIGITS-1:0] digit_sel
);

    localparam int NREG  = NUM_DIGITS / 2;
    localparam int IDX_W = $clog2(NUM_DIGITS);
    localparam int CNT_W = $clog2(SLOT_CYCLES);

    logic [IDX_W-1:0]      digit_idx;
    logic [CNT_W-1:0]      slot_cnt;
    logic                  slot_last;
    logic [NREG-1:0][15:0] view_regs;
    logic                  view_decode;
    seg_t                  seg;

    segscan_timer #(.NUM_DIGITS(NUM_DIGITS), .SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .digit_idx (digit_idx),
        .slot_cnt  (slot_cnt),
        .slot_last (slot_last)
    );

    segscan_regbank #(.NUM_DIGITS(NUM_DIGITS)) u_regbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .mode_decode (mode_decode),
        .slot_last   (slot_last),
        .view_regs   (view_regs),
        .view_decode (view_decode)
    );

    segscan_glyph #(.NUM_DIGITS(NUM_DIGITS)) u_glyph (
        .view_regs   (view_regs),
        .view_decode (view_decode),
        .digit_idx   (digit_idx),
        .blank       (slot_cnt == '0),
        .seg         (seg)
    );

    assign seg_out = seg;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
        // Enables digit g while the scan index points at it.
        assign digit_sel[g] = (digit_idx == IDX_W'(g));
    end

    // R2: exactly one digit is enabled at any time
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(digit_sel));

    // R3: the segment lines are dark whenever the selected digit changes
    a_r3_blank_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digit_sel) |-> seg_out == 8'h00);

endmodule

// File: tb/segscan_ctrl_bench.sv
// Bench for segscan_ctrl with 8 digits and 4-clock slots.
module segscan_ctrl_bench;

    localparam int ND   = 8;
    localparam int SLOT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_decode = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  seg_out;
    logic [7:0]  digit_sel;

    int checks = 0;
    int errors = 0;

    logic [15:0] mreg [4];
    logic        mmode;
    logic [6:0]  font [16];

    always #2.5 clk = ~clk;

    segscan_ctrl #(.NUM_DIGITS(ND), .SLOT_CYCLES(SLOT)) u_segscan_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_decode(mode_decode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .seg_out(seg_out), .digit_sel(digit_sel)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_seg(int d, logic m);
        logic [15:0] r;
        if (m) begin
            r = mreg[1 + d / 4];
            return {mreg[0][d], font[r[(d % 4) * 4 +: 4]]};
        end
        r = mreg[d / 2];
        return r[(d % 2) * 8 +: 8];
    endfunction

    function automatic int idx_of(logic [7:0] sel);
        for (int i = 0; i < ND; i++) if (sel[i]) return i;
        return -1;
    endfunction

    task automatic host_write(logic [2:0] a, logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (int'(a) < (mmode ? 1 + ND / 4 : ND / 2)) mreg[a] = v;
    endtask

    task automatic set_mode(logic m);
        mode_decode = m; mmode = m;
    endtask

    // Waits for the first clock of a new slot (called at a negedge).
    task automatic wait_slot_start();
        logic [7:0] prev;
        do begin prev = digit_sel; @(negedge clk); end while (digit_sel == prev);
    endtask

    // Aligns to digit 0 and checks one full revolution plus the wrap.
    task automatic scan_all(string tag);
        logic [7:0] prev;
        do begin prev = digit_sel; @(negedge clk); end
        while (!(digit_sel == 8'h01 && prev != 8'h01));
        for (int d = 0; d < ND; d++) begin
            for (int c = 0; c < SLOT; c++) begin
                if (d != 0 || c != 0) @(negedge clk);
                check({tag, " R2 digit_sel"}, 16'(digit_sel), 16'(8'h01 << d));
                if (c == 0) check({tag, " R3 blank"}, 16'(seg_out), 16'h0);
                else        check({tag, " segments"}, 16'(seg_out), 16'(exp_seg(d, mmode)));
            end
        end
        @(negedge clk);
        check({tag, " R2 wrap"}, 16'(digit_sel), 16'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        font = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33, 7'h5B, 7'h5F, 7'h72,
                 7'h7F, 7'h7B, 7'h01, 7'h4F, 7'h37, 7'h0D, 7'h0F, 7'h00};
        for (int i = 0; i < 4; i++) mreg[i] = '0;
        mmode = 1'b1;

        // R1: reset state in decode mode
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 select after reset", 16'(digit_sel), 16'h01);
        check("R1 blank first clock", 16'(seg_out), 16'h0);
        @(negedge clk);
        check("R1 decode zero glyph", 16'(seg_out), 16'h7E);
        scan_all("R1 decode reset");

        // R1: reset state in raw mode
        host_write(3'd1, 16'h1234);
        @(negedge clk);
        rst_n = 1'b0; set_mode(1'b0);
        for (int i = 0; i < 4; i++) mreg[i] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 raw dark", 16'(seg_out), 16'h0);
        scan_all("R1 raw reset");

        // R4 R5 R6: every code at shifting positions with varied points
        set_mode(1'b1);
        for (int p = 0; p < 4; p++) begin
            logic [15:0] nib [2];
            for (int g = 0; g < 2; g++) begin
                nib[g] = '0;
                for (int k = 0; k < 4; k++)
                    nib[g][k * 4 +: 4] = 4'((g * 4 + k + 4 * p + p) & 15);
            end
            host_write(3'd0, 16'(8'hA5 ^ (8'h33 << p)));
            host_write(3'd1, nib[0]);
            host_write(3'd2, nib[1]);
            scan_all("R4 R5 R6 decode sweep");
        end
        for (int c = 0; c < 16; c++) begin
            logic [15:0] v;
            v = {4'(c), 4'(c), 4'(c), 4'(c)};
            host_write(3'd0, 16'(c * 16'h0101));
            host_write(3'd1, v);
            host_write(3'd2, v);
            scan_all("R4 font code");
        end

        // R7: raw bytes and a walking segment bit
        set_mode(1'b0);
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++)
                host_write(3'(r), {8'((r * 74 + 37 + p * 91) & 255), 8'((r * 74 + p * 91) & 255)});
            scan_all("R7 raw bytes");
        end
        for (int p = 0; p < 8; p++) begin
            for (int r = 0; r < 4; r++)
                host_write(3'(r), {8'(8'h01 << ((2 * r + 1 + p) % 8)), 8'(8'h01 << ((2 * r + p) % 8))});
            scan_all("R7 walking bit");
        end

        // R9: writes beyond the active layout are dropped
        host_write(3'd3, 16'h1234);
        host_write(3'd4, 16'hFFFF);
        host_write(3'd7, 16'hFFFF);
        scan_all("R9 raw out of range");
        set_mode(1'b1);
        host_write(3'd3, 16'hBEEF);
        host_write(3'd5, 16'hBEEF);
        host_write(3'd0, 16'h0000);
        host_write(3'd1, 16'h8888);
        host_write(3'd2, 16'h8888);
        scan_all("R9 decode");
        set_mode(1'b0);
        scan_all("R9 reg3 kept after decode write");

        // R8: a mid-slot write shows from the next slot only
        set_mode(1'b1);
        scan_all("R8 setup");
        wait_slot_start();
        begin
            int d;
            logic [7:0] old_v;
            d = idx_of(digit_sel);
            old_v = exp_seg(d, 1'b1);
            wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'hFFFF;
            @(negedge clk);
            wr_en = 1'b0; mreg[0] = 16'hFFFF;
            for (int c = 1; c < SLOT; c++) begin
                if (c > 1) @(negedge clk);
                check("R8 write held in slot", 16'(seg_out), 16'(old_v));
            end
            @(negedge clk);
            check("R8 next slot blank", 16'(seg_out), 16'h0);
            @(negedge clk);
            check("R8 write visible", 16'(seg_out), 16'(exp_seg((d + 1) % ND, 1'b1)));
        end

        // R8: a mid-slot mode change shows from the next slot only
        wait_slot_start();
        begin
            int d;
            logic [7:0] old_v;
            d = idx_of(digit_sel);
            old_v = exp_seg(d, 1'b1);
            set_mode(1'b0);
            for (int c = 1; c < SLOT; c++) begin
                @(negedge clk);
                check("R8 mode held in slot", 16'(seg_out), 16'(old_v));
            end
            @(negedge clk);
            @(negedge clk);
            check("R8 mode visible", 16'(seg_out), 16'(exp_seg((d + 1) % ND, 1'b0)));
        end
        scan_all("R8 after mode change");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule